// File: doc/BRIEF.md
# Transition-Filtered Status Register

This block keeps one 16-bit status word in five views that share a single bit assignment: the live condition, a rising-edge filter mask, a falling-edge filter mask, a sticky event word and an enable mask. Every clock the condition inputs are sampled. A bit of the event word latches when its condition bit makes a transition that the matching filter mask selects. It then stays set until software collects it.

A write port loads the three masks and a read port returns any of the five views. A read of the event view also clears it. A separate clear pulse empties the event word as well. The enabled events are OR-reduced into one summary bit, which feeds a single input bit of a higher-level register of the same kind. Chains of these blocks form a reporting tree.

The most significant bit is reserved in every view and always reads as zero, so each view is a non-negative number.

Top module: `xfilt_status_reg`

## Requirements
- R1: The condition view returns `cond_i` as sampled at the most recent clock edge (reset value 0); no write code alters it.
- R2: When a condition bit is 0 at one sampled edge and 1 at the next, and its rising-edge mask bit is 1, the matching event bit is 1 after that edge.
- R3: When a condition bit goes from 1 to 0 between sampled edges, and its falling-edge mask bit is 1, the matching event bit is 1 after that edge.
- R4: A transition whose filter mask bit is 0 leaves the event bit unchanged.
- R5: Event bits stay set until an edge at which `clr_i` is high, or `rd_en` is high with `rd_sel`=3. An event bit that a transition selects at that same edge stays set.
- R6: `summary_o` is 1 exactly when some event bit and its enable bit are both 1.
- R7: After reset the rising-edge mask reads 0x7FFF, and the falling-edge mask, enable mask, event word and condition all read 0.
- R8: Bit 15 of every view reads 0. Writes to bit 15 of a mask are dropped, and a transition on condition bit 15 sets no event.
- R9: Read codes on `rd_sel` are 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 enable; codes 5 to 7 read 0. Write codes on `wr_sel` are 0 rising mask, 1 falling mask, 2 enable; code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | 16 | Live hardware condition bits |
| clr_i | input | 1 | Clears the event word |
| wr_en | input | 1 | Mask write strobe |
| wr_sel | input | 2 | Mask select for the write |
| wr_data | input | 16 | Mask write data |
| rd_en | input | 1 | Read strobe; with code 3 it clears the event word |
| rd_sel | input | 3 | View select for the read |
| rd_data | output | 16 | Selected view, combinational |
| summary_o | output | 1 | OR of the enabled events |

## Verification
The bench builds the block with the default width of 16. At that width the reserved top bit sits exactly where software expects it, so forced-ones writes and a toggling condition bit 15 can be shown to leave every view below 0x8000. The directed scenarios drive single and multi-bit rising and falling transitions against both filter masks. They also pair a transition with a clear in the same cycle, and move the enable mask across a pending event to show the summary bit following it.

// File: rtl/xfilt_status_reg.sv
module xfilt_status_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic         clr_i,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         summary_o
);

  localparam logic [W-1:0] VMASK = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cond_q, ptr_q, ntr_q, en_q, ev_q;
  logic [W-1:0] cond_s, hit;
  logic         ev_clr;

  assign cond_s = cond_i & VMASK;
  assign hit    = ((cond_s & ~cond_q & ptr_q) | (~cond_s & cond_q & ntr_q)) & VMASK;
  assign ev_clr = clr_i | (rd_en && rd_sel == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ptr_q  <= VMASK;
      ntr_q  <= '0;
      en_q   <= '0;
      ev_q   <= '0;
    end else begin
      cond_q <= cond_s;
      ev_q   <= (ev_clr ? '0 : ev_q) | hit;
      if (wr_en) begin
        case (wr_sel)
          2'd0:    ptr_q <= wr_data & VMASK;
          2'd1:    ntr_q <= wr_data & VMASK;
          2'd2:    en_q  <= wr_data & VMASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = cond_q;
      3'd1:    rd_data = ptr_q;
      3'd2:    rd_data = ntr_q;
      3'd3:    rd_data = ev_q;
      3'd4:    rd_data = en_q;
      default: rd_data = '0;
    endcase
  end

  assign summary_o = |(ev_q & en_q);

endmodule

// File: rtl/xfilt_status_reg_chk.sv
module xfilt_status_reg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cond_i,
  input logic         clr_i,
  input logic         rd_en,
  input logic [2:0]   rd_sel,
  input logic [W-1:0] rd_data,
  input logic         summary_o,
  input logic [W-1:0] cond_q,
  input logic [W-1:0] ptr_q,
  input logic [W-1:0] ntr_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] ev_q
);

  logic [W-1:0] rise_sel, fall_sel;
  logic         clearing;
  assign rise_sel = cond_i & ~cond_q & ptr_q;
  assign fall_sel = ~cond_i & cond_q & ntr_q;
  assign clearing = clr_i | (rd_en && rd_sel == 3'd3);

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_sel != '0) |=> ((ev_q & $past(rise_sel)) == $past(rise_sel)));

  p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_sel != '0) |=> ((ev_q & $past(fall_sel)) == $past(fall_sel)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clearing |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clearing && rise_sel == '0 && fall_sel == '0) |=> (ev_q == '0));

  p_summary_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> (ev_q != '0 && en_q != '0));

  p_msb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[W-1] && !ev_q[W-1] && !ptr_q[W-1] && !ntr_q[W-1] && !en_q[W-1]);

endmodule

bind xfilt_status_reg xfilt_status_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_s), .clr_i(clr_i), .rd_en(rd_en),
  .rd_sel(rd_sel), .rd_data(rd_data), .summary_o(summary_o), .cond_q(cond_q),
  .ptr_q(ptr_q), .ntr_q(ntr_q), .en_q(en_q), .ev_q(ev_q)
);

// File: tb/xfilt_status_reg_test.sv
`timescale 1ns/100ps
module xfilt_status_reg_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cond_i = '0, wr_data = '0, rd_data;
  logic        clr_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0, summary_o;
  logic [1:0]  wr_sel = '0;
  logic [2:0]  rd_sel = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xfilt_status_reg #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .clr_i(clr_i), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .summary_o(summary_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [2:0] sel, input string req, input logic [15:0] exp);
    rd_sel = sel; #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic setcond(input logic [15:0] v);
    cond_i = v; tick();
  endtask

  task automatic t_reset();
    peek(3'd1, "R7 rising mask", 16'h7FFF);
    peek(3'd2, "R7 falling mask", 16'h0000);
    peek(3'd4, "R7 enable", 16'h0000);
    peek(3'd3, "R7 event", 16'h0000);
    peek(3'd0, "R7 condition", 16'h0000);
    check("R7 summary", {15'd0, summary_o}, 16'h0000);
  endtask

  task automatic t_rise();
    setcond(16'h0005);
    peek(3'd0, "R1 condition sampled", 16'h0005);
    peek(3'd3, "R2 rising edges latched", 16'h0005);
    rd_sel = 3'd3; rd_en = 1'b1; tick(); rd_en = 1'b0;
    peek(3'd3, "R5 destructive read clears", 16'h0000);
  endtask

  task automatic t_fall();
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0000);
    setcond(16'h0001);
    peek(3'd3, "R3 falling edge latched", 16'h0004);
    setcond(16'h0000);
    peek(3'd3, "R4 unselected fall ignored", 16'h0004);
    tick();
    peek(3'd3, "R5 event held", 16'h0004);
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    peek(3'd3, "R5 clear pulse", 16'h0000);
    setcond(16'h0002);
    peek(3'd3, "R4 rise with mask 0 ignored", 16'h0000);
    setcond(16'h0000);
  endtask

  task automatic t_collide();
    wr(2'd0, 16'h0010);
    cond_i = 16'h0010; clr_i = 1'b1; tick(); clr_i = 1'b0;
    peek(3'd3, "R5 edge wins over clear", 16'h0010);
  endtask

  task automatic t_summary();
    wr(2'd2, 16'h0020);
    check("R6 summary off, not enabled", {15'd0, summary_o}, 16'h0000);
    wr(2'd2, 16'h0010);
    check("R6 summary on", {15'd0, summary_o}, 16'h0001);
    rd_sel = 3'd3; rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R6 summary drops after read", {15'd0, summary_o}, 16'h0000);
  endtask

  task automatic t_msb();
    wr(2'd0, 16'hFFFF);
    peek(3'd1, "R8 rising mask msb", 16'h7FFF);
    wr(2'd1, 16'hFFFF);
    peek(3'd2, "R8 falling mask msb", 16'h7FFF);
    wr(2'd2, 16'hFFFF);
    peek(3'd4, "R8 enable msb", 16'h7FFF);
    setcond(16'h8000);
    peek(3'd0, "R8 condition msb", 16'h0000);
    peek(3'd3, "R8 no msb event", 16'h0010);
    setcond(16'h0000);
    peek(3'd3, "R8 no msb fall event", 16'h0010);
  endtask

  task automatic t_sel();
    wr(2'd0, 16'h0123);
    wr(2'd1, 16'h0456);
    wr(2'd2, 16'h0789);
    wr(2'd3, 16'h7AAA);
    peek(3'd1, "R9 code 3 write no rising change", 16'h0123);
    peek(3'd2, "R9 code 3 write no falling change", 16'h0456);
    peek(3'd4, "R9 code 3 write no enable change", 16'h0789);
    peek(3'd0, "R1 code 3 write no condition change", 16'h0000);
    for (int s = 5; s < 8; s++) peek(3'(s), "R9 unused read code", 16'h0000);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rise();
    t_fall();
    t_collide();
    t_summary();
    t_msb();
    t_sel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule